// File: doc/BRIEF.md
# Memory-to-Stream Block Mover

This engine copies a contiguous region of memory onto an outgoing data stream. Software sets it up through four word-wide registers: control, status, source address and byte count. It fetches the data over a simple burst read port and forwards each returned word as one stream beat. The last beat of a transfer is marked, and the unused bytes of a final partial word are masked out. On completion it raises a sticky status bit and, if enabled, an interrupt.

Software first sets the run bit and waits for the halted flag to drop. It may then write the source address and the interrupt enables in any order. The transfer is launched by writing the byte count, which must be the last write. A full-mode parameter selects how requests are formed. In full mode, requests are cut into bursts of at most MAX_BURST beats that never straddle a 4 KB page. In reduced mode, one request covers the whole transfer and the page rule is left to software.

Top module: `m2s_dma`

## Requirements
- R1: After reset the status register (offset 0x4) reads halted (bit 0) = 1 with done (bit 1) and error (bit 2) clear. The interrupt is low, and no read request or stream beat is issued.
- R2: The control register sits at offset 0x0 (bit 0 run, bit 1 done interrupt enable, bit 2 error interrupt enable). Setting run clears halted on the following cycle. While no transfer is active, clearing run sets halted on the following cycle.
- R3: A non-zero write to the byte-count register (offset 0xC) starts a transfer of ceil(count/BYTES) beats from the address held at offset 0x8. This happens only while run is set and no transfer is active. Beat k carries the memory word at source + k*BYTES.
- R4: Writing zero to the byte-count register starts nothing.
- R5: A byte-count write while a transfer is in progress, or while the channel is stopped, starts nothing.
- R6: Each read request carries a beat count from 1 to MAX_BURST, and the requests together cover the whole transfer in address order. A request holds its address and count stable until it is accepted.
- R7: In full mode, no request crosses a 4 KB address boundary.
- R8: The stream last flag is high on the final beat only. Keep is all ones on every beat except a final partial word, where only the low (count mod BYTES) byte lanes are set.
- R9: The handshake of the final beat sets done (status bit 1). Writing 1 to that bit clears it.
- R10: The interrupt is high exactly when (done and its enable) or (error and its enable) holds.
- R11: A start attempt with a source address that is not a multiple of BYTES sets error (status bit 2, write 1 to clear) and issues no request.
- R12: When run is cleared during a transfer, the burst in flight completes and no further request is made. Halted is then set and done stays clear.
- R13: In reduced mode the whole transfer is one request, even across a 4 KB boundary. A count above MAX_BURST*BYTES sets error instead of starting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Burst start byte address |
| rd_req_beats | output | BW | Beats in the burst |
| rd_data_valid | input | 1 | Read data valid |
| rd_data_ready | output | 1 | Read data taken |
| rd_data | input | DW | Read data word |
| st_valid | output | 1 | Stream beat valid |
| st_ready | input | 1 | Stream sink ready |
| st_data | output | DW | Stream data |
| st_keep | output | DW/8 | Stream byte enables |
| st_last | output | 1 | Final beat of the transfer |

## Verification
A wrong beat counter shows up at the stream port on the very next beat. It appears as a missing or early last flag, an extra or absent beat, or a wrong keep mask, and the scoreboard catches it at that beat. A wrong address pointer or burst sizing shows up as a mismatched read request at the moment it is accepted. It is visible before any of its data returns. Faults in run/halted tracking or start qualification show up within a few cycles, as a status bit or request count that differs from the expected value.

// File: rtl/m2s_dma.sv
module m2s_dma #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LEN_W = 16,
  parameter int MAX_BURST = 16,
  parameter bit REDUCED = 1'b0,
  localparam int BYTES = DW / 8,
  localparam int SH = $clog2(BYTES),
  localparam int BW = $clog2(MAX_BURST + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [AW-1:0]    rd_req_addr,
  output logic [BW-1:0]    rd_req_beats,
  input  logic             rd_data_valid,
  output logic             rd_data_ready,
  input  logic [DW-1:0]    rd_data,
  output logic             st_valid,
  input  logic             st_ready,
  output logic [DW-1:0]    st_data,
  output logic [BYTES-1:0] st_keep,
  output logic             st_last
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA} state_t;

  state_t            state;
  logic              run_q, done_ie_q, err_ie_q;
  logic              halted_q, done_q, err_q;
  logic [AW-1:0]     src_q, cur_addr;
  logic [LEN_W-1:0]  len_q, beats_left, cap;
  logic [BW-1:0]     burst_left, burst_sz;
  logic [SH-1:0]     tail_q;
  logic [BYTES-1:0]  tail_mask;

  wire wr_ctl = reg_wr && reg_addr == 4'h0;
  wire wr_sts = reg_wr && reg_addr == 4'h4;
  wire wr_src = reg_wr && reg_addr == 4'h8;
  wire wr_len = reg_wr && reg_addr == 4'hC;

  wire [LEN_W-1:0] len_in   = reg_wdata[LEN_W-1:0];
  wire [LEN_W-1:0] beats_in = (len_in >> SH) + LEN_W'(|len_in[SH-1:0]);
  wire aligned  = src_q[SH-1:0] == '0;
  wire too_long = REDUCED && beats_in > LEN_W'(MAX_BURST);
  wire len_go   = wr_len && run_q && state == S_IDLE && len_in != '0;
  wire start    = len_go && aligned && !too_long;
  wire bad      = len_go && (!aligned || too_long);

  wire [12:0] room_bytes = 13'd4096 - {1'b0, cur_addr[11:0]};
  wire [12:0] room       = room_bytes >> SH;

  always_comb begin
    cap = beats_left;
    if (!REDUCED) begin
      if (cap > LEN_W'(MAX_BURST)) cap = LEN_W'(MAX_BURST);
      if (cap > LEN_W'(room)) cap = LEN_W'(room);
    end
    burst_sz = cap[BW-1:0];
  end

  wire fire  = st_valid && st_ready;
  wire final_beat = fire && beats_left == LEN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur_addr   <= '0;
      beats_left <= '0;
      burst_left <= '0;
      tail_q     <= '0;
      len_q      <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cur_addr   <= src_q;
          beats_left <= beats_in;
          tail_q     <= len_in[SH-1:0];
          len_q      <= len_in;
          state      <= S_REQ;
        end
        S_REQ: if (rd_req_ready) begin
          cur_addr   <= cur_addr + (AW'(burst_sz) << SH);
          burst_left <= burst_sz;
          state      <= S_DATA;
        end
        default: if (fire) begin
          beats_left <= beats_left - 1'b1;
          burst_left <= burst_left - 1'b1;
          if (burst_left == BW'(1))
            state <= (beats_left == LEN_W'(1) || !run_q) ? S_IDLE : S_REQ;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; done_ie_q <= 1'b0; err_ie_q <= 1'b0;
      halted_q <= 1'b1; done_q <= 1'b0; err_q <= 1'b0;
      src_q <= '0;
    end else begin
      if (wr_ctl) {err_ie_q, done_ie_q, run_q} <= reg_wdata[2:0];
      if (wr_src) src_q <= reg_wdata[AW-1:0];
      if (run_q) halted_q <= 1'b0;
      else if (state == S_IDLE) halted_q <= 1'b1;
      if (final_beat) done_q <= 1'b1;
      else if (wr_sts && reg_wdata[1]) done_q <= 1'b0;
      if (bad) err_q <= 1'b1;
      else if (wr_sts && reg_wdata[2]) err_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      4'h0:    reg_rdata = {29'd0, err_ie_q, done_ie_q, run_q};
      4'h4:    reg_rdata = {29'd0, err_q, done_q, halted_q};
      4'h8:    reg_rdata = 32'(src_q);
      4'hC:    reg_rdata = 32'(len_q);
      default: reg_rdata = '0;
    endcase
  end

  assign tail_mask = (tail_q == '0) ? '1 : ((BYTES'(1) << tail_q) - BYTES'(1));

  assign irq           = (done_q && done_ie_q) || (err_q && err_ie_q);
  assign rd_req_valid  = state == S_REQ;
  assign rd_req_addr   = cur_addr;
  assign rd_req_beats  = burst_sz;
  assign rd_data_ready = state == S_DATA && st_ready;
  assign st_valid      = state == S_DATA && rd_data_valid;
  assign st_data       = rd_data;
  assign st_last       = state == S_DATA && beats_left == LEN_W'(1);
  assign st_keep       = st_last ? tail_mask : '1;

  p_beats_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_beats != '0 && rd_req_beats <= BW'(MAX_BURST));

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_beats));

  p_no_4k_cross_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !REDUCED && rd_req_valid |->
      14'(rd_req_addr[11:0]) + (14'(rd_req_beats) << SH) <= 14'd4096);

  p_keep_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_last |-> &st_keep);

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && st_last |=> reg_addr != 4'h4 || reg_rdata[1]);

  p_quiet_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_ie_q && !err_ie_q |-> !irq);

  p_halt_no_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |-> !rd_req_valid && !st_valid);

endmodule

// File: tb/test_m2s_dma.sv
module test_m2s_dma;
  localparam int BW = 5;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        reg_wr = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        irq, rd_req_valid, rd_req_ready = 0, rd_data_ready;
  logic [31:0] rd_req_addr, rd_data = 0, st_data;
  logic [BW-1:0] rd_req_beats;
  logic        rd_data_valid = 0, st_valid, st_ready = 0, st_last;
  logic [3:0]  st_keep;

  logic        l_wr = 0;
  logic [3:0]  l_addr = 0;
  logic [31:0] l_wdata = 0, l_rdata, l_req_addr, l_st_data;
  logic        l_irq, l_req_valid, l_data_ready, l_st_valid, l_st_last;
  logic [BW-1:0] l_req_beats;
  logic [3:0]  l_st_keep;
  logic        l_zero = 0;
  logic [31:0] l_zdata = 0;

  m2s_dma i_m2s_dma (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq,
    .rd_req_valid, .rd_req_ready, .rd_req_addr, .rd_req_beats,
    .rd_data_valid, .rd_data_ready, .rd_data,
    .st_valid, .st_ready, .st_data, .st_keep, .st_last);

  m2s_dma #(.REDUCED(1'b1)) i_lite (
    .clk, .rst_n, .reg_wr(l_wr), .reg_addr(l_addr), .reg_wdata(l_wdata),
    .reg_rdata(l_rdata), .irq(l_irq), .rd_req_valid(l_req_valid),
    .rd_req_ready(l_zero), .rd_req_addr(l_req_addr), .rd_req_beats(l_req_beats),
    .rd_data_valid(l_zero), .rd_data_ready(l_data_ready), .rd_data(l_zdata),
    .st_valid(l_st_valid), .st_ready(l_zero), .st_data(l_st_data),
    .st_keep(l_st_keep), .st_last(l_st_last));

  int n_chk = 0, n_err = 0, req_cnt = 0, beat_cnt = 0;
  bit done_flag = 0;
  logic [31:0] exp_data[$];
  logic [3:0]  exp_keep[$];
  logic        exp_last[$];
  logic [31:0] exp_raddr[$];
  int          exp_rbeats[$];

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {8'hA5, a[23:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic wr(input bit lite, input logic [3:0] a, input logic [31:0] d);
    if (lite) begin l_wr = 1; l_addr = a; l_wdata = d; end
    else begin reg_wr = 1; reg_addr = a; reg_wdata = d; end
    @(negedge clk);
    l_wr = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic xfer(input logic [31:0] src, input int len);
    int beats, tail, rem, n, room;
    logic [31:0] a;
    beats = (len + 3) / 4; tail = len % 4;
    for (int i = 0; i < beats; i++) begin
      exp_data.push_back(word_at(src + 32'(4 * i)));
      exp_keep.push_back((i == beats - 1 && tail != 0) ? 4'((1 << tail) - 1) : 4'hF);
      exp_last.push_back(i == beats - 1);
    end
    a = src; rem = beats;
    while (rem > 0) begin
      room = (4096 - int'(a % 4096)) / 4;
      n = rem < 16 ? rem : 16;
      if (n > room) n = room;
      exp_raddr.push_back(a); exp_rbeats.push_back(n);
      a += 32'(4 * n); rem -= n;
    end
    wr(0, 4'h8, src);
    wr(0, 4'hC, 32'(len));
  endtask

  task automatic wait_end(input string tag);
    logic [31:0] s;
    int t = 0;
    do begin @(negedge clk); rd(4'h4, s); t++; end
    while (s[2:1] == 0 && t < 3000);
    @(negedge clk);
    chk({tag, " transfer ended"}, 32'(t < 3000), 1);
    chk({tag, " all beats seen"}, exp_data.size(), 0);
    chk({tag, " all requests seen"}, exp_raddr.size(), 0);
  endtask

  logic [31:0] mem_addr = 0;
  int pend = 0;
  logic [15:0] lfsr = 16'hACE1;

  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd_req_ready = lfsr[0] | lfsr[3];
      st_ready = lfsr[5] | lfsr[7] | lfsr[9];
      rd_data_valid = pend > 0 && (lfsr[2] | lfsr[11]);
      rd_data = word_at(mem_addr);
      #1;
      if (rd_data_valid && rd_data_ready) begin mem_addr += 4; pend--; end
      if (rd_req_valid && rd_req_ready) begin
        req_cnt++;
        if (exp_raddr.size() == 0) chk("R6 unexpected request", rd_req_addr, 32'hFFFFFFFF);
        else begin
          chk("R6 R7 request address", rd_req_addr, exp_raddr.pop_front());
          chk("R6 R7 request beats", 32'(rd_req_beats), 32'(exp_rbeats.pop_front()));
        end
        mem_addr = rd_req_addr; pend = int'(rd_req_beats);
      end
      if (st_valid && st_ready) begin
        beat_cnt++;
        if (exp_data.size() == 0) chk("R3 unexpected beat", st_data, 32'hFFFFFFFF);
        else begin
          chk("R3 beat data", st_data, exp_data.pop_front());
          chk("R8 beat keep", 32'(st_keep), 32'(exp_keep.pop_front()));
          chk("R8 beat last", 32'(st_last), 32'(exp_last.pop_front()));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] s;
    int r0, b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(4'h4, s);
    chk("R1 reset status", s, 32'h1);
    chk("R1 reset irq", 32'(irq), 0);
    chk("R1 reset request", 32'(rd_req_valid), 0);
    chk("R1 reset stream", 32'(st_valid), 0);

    @(negedge clk);
    wr(0, 4'h0, 32'h7);
    @(negedge clk);
    rd(4'h4, s);
    chk("R2 halted clears", 32'(s[0]), 0);

    xfer(32'h100, 32);
    wait_end("R3 R9 short");
    rd(4'h4, s);
    chk("R9 done set", 32'(s[1]), 1);
    chk("R10 irq with done", 32'(irq), 1);
    wr(0, 4'h0, 32'h1);
    #1 chk("R10 irq masked", 32'(irq), 0);
    wr(0, 4'h4, 32'h2);
    rd(4'h4, s);
    chk("R9 done cleared", 32'(s[1]), 0);
    wr(0, 4'h0, 32'h7);

    xfer(32'hFF0, 70);
    wait_end("R7 R8 page");
    wr(0, 4'h4, 32'h2);
    xfer(32'h3000, 200);
    wait_end("R6 long");
    wr(0, 4'h4, 32'h2);

    r0 = req_cnt;
    wr(0, 4'hC, 0);
    repeat (20) @(negedge clk);
    chk("R4 zero length no request", 32'(req_cnt), 32'(r0));
    rd(4'h4, s);
    chk("R4 zero length no done", 32'(s[1]), 0);

    r0 = req_cnt;
    xfer(32'h4000, 128);
    wr(0, 4'hC, 4);
    wait_end("R5 busy");
    chk("R5 busy write ignored", 32'(req_cnt - r0), 2);
    wr(0, 4'h4, 32'h2);

    r0 = req_cnt;
    wr(0, 4'h8, 32'h102);
    wr(0, 4'hC, 8);
    rd(4'h4, s);
    chk("R11 error set", 32'(s[2]), 1);
    chk("R10 irq on error", 32'(irq), 1);
    repeat (10) @(negedge clk);
    chk("R11 no request", 32'(req_cnt), 32'(r0));
    wr(0, 4'h4, 32'h4);
    rd(4'h4, s);
    chk("R11 error cleared", 32'(s[2]), 0);
    chk("R10 irq low", 32'(irq), 0);

    b0 = beat_cnt;
    xfer(32'h2000, 160);
    while (beat_cnt - b0 < 5) @(negedge clk);
    wr(0, 4'h0, 32'h6);
    begin
      int t = 0;
      do begin @(negedge clk); rd(4'h4, s); t++; end while (!s[0] && t < 500);
    end
    chk("R12 halted after stop", 32'(s[0]), 1);
    chk("R12 done stays clear", 32'(s[1]), 0);
    chk("R12 stops on burst edge", 32'((beat_cnt - b0) % 16 == 0 && beat_cnt - b0 < 40), 1);
    exp_data.delete(); exp_keep.delete(); exp_last.delete();
    exp_raddr.delete(); exp_rbeats.delete();

    r0 = req_cnt;
    wr(0, 4'h8, 32'h500);
    wr(0, 4'hC, 16);
    repeat (20) @(negedge clk);
    chk("R5 halted write ignored", 32'(req_cnt), 32'(r0));

    wr(0, 4'h0, 32'h1);
    @(negedge clk);
    rd(4'h4, s);
    chk("R2 halted clears again", 32'(s[0]), 0);
    wr(0, 4'h0, 32'h0);
    @(negedge clk);
    rd(4'h4, s);
    chk("R2 halted sets when idle", 32'(s[0]), 1);

    wr(1, 4'h0, 32'h1);
    @(negedge clk);
    wr(1, 4'h8, 32'hFF8);
    wr(1, 4'hC, 128);
    l_addr = 4'h4; #1;
    chk("R13 oversize error", 32'(l_rdata[2]), 1);
    chk("R13 oversize no request", 32'(l_req_valid), 0);
    wr(1, 4'hC, 24);
    #1;
    chk("R13 single request", 32'(l_req_valid), 1);
    chk("R13 request address", l_req_addr, 32'hFF8);
    chk("R13 request spans page", 32'(l_req_beats), 6);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule